// File: doc/BRIEF.md
# Converter Cell Fault Protection Controller

This block is the fast hardware guard that sits beside one half-bridge cell of a multilevel converter. It receives a digitized capacitor voltage and a digitized cell current every clock, along with two comparator flags from the analog side. It compares these against programmable limits. When the capacitor voltage collapses below a non-operating floor, the block treats it as a shorted bridge. When the current stays over its limit for longer than a qualifying window, the block treats it as an overcurrent. In either case it trips.

A trip removes both gate drives in the same cycle and fires a fast bypass switch. After a programmable relay-closing time, it also commands the slow permanent bypass relay, and from then on both stay on. The fault is latched as a code with a level interrupt so that the local processor can report it on its next communication exchange. The latch is released only by an explicit clear, and only when no fault condition is present.

During normal operation, the block turns the single modulator PWM bit into complementary high-side and low-side gate commands, with a programmable dead band at every transition.

Top module: `cell_guard`

## Requirements
- R1: While reset is asserted and after reset releases, both gate outputs, triac_en, relay_en and fault_irq are 0, and fault_code is 0.
- R2: An undervoltage condition is present when volt_smp < volt_floor (unsigned) or uv_cmp is 1. It is latched as fault_code = 1 (undervoltage) at the next rising clock edge, and fault_irq goes to 1.
- R3: An over-limit sample is one with curr_smp > curr_limit (unsigned) or oc_cmp = 1. Overcurrent trips only when the over-limit condition is present at OC_CYCLES+1 consecutive clock edges, which is 10+1 at 100 MHz and so longer than 100 ns. The trip latches fault_code = 2 at that edge. Any under-limit sample restarts the count, so OC_CYCLES consecutive over-limit samples do not trip.
- R4: In the same cycle that a trip condition is present, and for as long as a fault is latched, gate_hi and gate_lo are both 0.
- R5: triac_en is 1 in the same cycle as the trip condition. relay_en rises exactly relay_time+1 clock edges after the edge that latches the fault. From then on, triac_en and relay_en both stay 1 until the fault is cleared.
- R6: gate_hi and gate_lo are never 1 together. After pwm_in changes, both are 0 for the first dead_cycles+1 clock edges, and the newly selected gate turns on at edge dead_cycles+2.
- R7: If undervoltage and overcurrent trip on the same edge, the code is 1. Once a code is latched, later conditions do not change it.
- R8: clear_req is ignored while any undervoltage or over-limit condition is present. A clear_req with no condition present returns fault_code, fault_irq, triac_en and relay_en to 0 at the next edge.
- R9: With no fault and a steady pwm_in, gate_hi equals pwm_in and gate_lo equals its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| volt_smp | input | VW | Capacitor voltage sample |
| volt_floor | input | VW | Non-operating voltage floor |
| uv_cmp | input | 1 | Undervoltage comparator flag |
| curr_smp | input | IW | Cell current magnitude sample |
| curr_limit | input | IW | Nominal current limit |
| oc_cmp | input | 1 | Overcurrent comparator flag |
| relay_time | input | RW | Fast-switch hold time before relay command, in cycles |
| dead_cycles | input | DW | Dead band length, in cycles |
| pwm_in | input | 1 | Modulator PWM (1 = high side) |
| clear_req | input | 1 | Fault clear request |
| gate_hi | output | 1 | High-side gate command |
| gate_lo | output | 1 | Low-side gate command |
| triac_en | output | 1 | Fast bypass switch enable |
| relay_en | output | 1 | Permanent bypass relay enable |
| fault_code | output | 2 | Latched fault (0 none, 1 undervoltage, 2 overcurrent) |
| fault_irq | output | 1 | Interrupt to the local processor, high while a fault is latched |

## Verification
An off-by-one in the overcurrent counter shows at the ports as a trip one cycle early or one cycle late. The stimulus therefore holds an over-limit current for exactly OC_CYCLES edges and then for one more, and watches the gates and the code on every cycle. A wrong bypass sequencer state shows as relay_en rising on the wrong edge or dropping without a clear. The relay edge is timed exactly, and both enables are then held. A dead-band counter fault shows within a few cycles of a PWM change as overlapping gates or a late turn-on. Randomized PWM patterns, together with short over-limit bursts that must not trip, exercise both paths continuously.

// File: rtl/cell_guard_pkg.sv
package cell_guard_pkg;

  typedef enum logic [1:0] {
    FC_NONE      = 2'd0,
    FC_UNDERVOLT = 2'd1,
    FC_OVERCUR   = 2'd2
  } fault_code_e;

  typedef enum logic [1:0] {
    BY_IDLE = 2'd0,
    BY_FAST = 2'd1,
    BY_PERM = 2'd2
  } bypass_st_e;

  // unsigned compare, samples zero-extended to 32 bits by the caller
  function automatic logic is_below(input logic [31:0] smp, input logic [31:0] floor_v);
    return smp < floor_v;
  endfunction

  function automatic logic is_above(input logic [31:0] smp, input logic [31:0] lim);
    return smp > lim;
  endfunction

  // undervoltage wins when both trip together
  function automatic fault_code_e pick_code(input logic uv, input logic oc);
    if (uv) return FC_UNDERVOLT;
    if (oc) return FC_OVERCUR;
    return FC_NONE;
  endfunction

endpackage

// File: rtl/oc_filter.sv
module oc_filter #(
  parameter int OC_CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic over,
  output logic trip
);
  localparam int CW = $clog2(OC_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(OC_CYCLES);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            run_q <= '0;
    else if (!over)        run_q <= '0;
    else if (run_q != LIM) run_q <= run_q + 1'b1;
  end

  assign trip = over && (run_q == LIM);
endmodule

// File: rtl/dead_band.sv
module dead_band #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwm,
  input  logic [DW-1:0] dead,
  output logic          hi_q,
  output logic          lo_q
);
  logic          cmd_q;
  logic [DW-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= 1'b0;
      wait_q <= '0;
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
    end else if (pwm != cmd_q) begin
      cmd_q  <= pwm;
      wait_q <= dead;
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
    end else if (wait_q != '0) begin
      wait_q <= wait_q - 1'b1;
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
    end else begin
      hi_q   <= cmd_q;
      lo_q   <= ~cmd_q;
    end
  end
endmodule

// File: rtl/bypass_seq.sv
module bypass_seq
  import cell_guard_pkg::*;
#(
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trip,
  input  logic          release_i,
  input  logic [RW-1:0] hold_time,
  output logic          triac_en,
  output logic          relay_en
);
  bypass_st_e    st_q;
  logic [RW-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= BY_IDLE;
      tmr_q <= '0;
    end else if (release_i) begin
      st_q  <= BY_IDLE;
      tmr_q <= '0;
    end else begin
      case (st_q)
        BY_IDLE: if (trip) begin
          st_q  <= BY_FAST;
          tmr_q <= hold_time;
        end
        BY_FAST: begin
          if (tmr_q != '0) tmr_q <= tmr_q - 1'b1;
          else             st_q  <= BY_PERM;
        end
        default: st_q <= BY_PERM;
      endcase
    end
  end

  assign triac_en = (st_q != BY_IDLE) || trip;
  assign relay_en = (st_q == BY_PERM);
endmodule

// File: rtl/cell_guard.sv
module cell_guard
  import cell_guard_pkg::*;
#(
  parameter int VW        = 12,
  parameter int IW        = 12,
  parameter int OC_CYCLES = 10,
  parameter int RW        = 16,
  parameter int DW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] volt_smp,
  input  logic [VW-1:0] volt_floor,
  input  logic          uv_cmp,
  input  logic [IW-1:0] curr_smp,
  input  logic [IW-1:0] curr_limit,
  input  logic          oc_cmp,
  input  logic [RW-1:0] relay_time,
  input  logic [DW-1:0] dead_cycles,
  input  logic          pwm_in,
  input  logic          clear_req,
  output logic          gate_hi,
  output logic          gate_lo,
  output logic          triac_en,
  output logic          relay_en,
  output logic [1:0]    fault_code,
  output logic          fault_irq
);
  // named internal events, observed by the bound checker
  logic        uv_now;
  logic        oc_over;
  logic        oc_trip;
  logic        trip_evt;
  logic        fault_active;
  logic        clr_ok;
  logic        hi_raw;
  logic        lo_raw;
  fault_code_e code_q;

  assign uv_now  = is_below(32'(volt_smp), 32'(volt_floor)) || uv_cmp;
  assign oc_over = is_above(32'(curr_smp), 32'(curr_limit)) || oc_cmp;

  oc_filter #(.OC_CYCLES(OC_CYCLES)) u_ocf (
    .clk  (clk),
    .rst_n(rst_n),
    .over (oc_over),
    .trip (oc_trip)
  );

  assign trip_evt     = uv_now || oc_trip;
  assign fault_active = (code_q != FC_NONE);
  assign clr_ok       = clear_req && fault_active && !uv_now && !oc_over;

  always_ff @(posedge clk) begin
    if (!rst_n)                        code_q <= FC_NONE;
    else if (clr_ok)                   code_q <= FC_NONE;
    else if (!fault_active && trip_evt) code_q <= pick_code(uv_now, oc_trip);
  end

  dead_band #(.DW(DW)) u_db (
    .clk  (clk),
    .rst_n(rst_n),
    .pwm  (pwm_in),
    .dead (dead_cycles),
    .hi_q (hi_raw),
    .lo_q (lo_raw)
  );

  bypass_seq #(.RW(RW)) u_byp (
    .clk      (clk),
    .rst_n    (rst_n),
    .trip     (trip_evt),
    .release_i(clr_ok),
    .hold_time(relay_time),
    .triac_en (triac_en),
    .relay_en (relay_en)
  );

  // kill path is combinational: no register between a trip and the gates
  assign gate_hi    = hi_raw && !trip_evt && !fault_active;
  assign gate_lo    = lo_raw && !trip_evt && !fault_active;
  assign fault_code = code_q;
  assign fault_irq  = fault_active;
endmodule

// File: rtl/cell_guard_chk.sv
module cell_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gate_hi,
  input logic       gate_lo,
  input logic       triac_en,
  input logic       relay_en,
  input logic [1:0] fault_code,
  input logic       uv_now,
  input logic       oc_over,
  input logic       oc_trip,
  input logic       clr_ok
);
  // R6
  gates_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  // R4
  latched_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code != 2'd0) |-> (!gate_hi && !gate_lo));

  // R2
  uv_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_now && fault_code == 2'd0) |=> (fault_code == 2'd1));

  // R3
  oc_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_trip |-> oc_over);

  // R5
  relay_with_triac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    relay_en |-> triac_en);

  // R5
  relay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    relay_en |=> (relay_en || fault_code == 2'd0));

  // R7
  code_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code != 2'd0 && !clr_ok) |=> $stable(fault_code));

  // R8
  clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ok |=> (fault_code == 2'd0 && !relay_en));
endmodule

bind cell_guard cell_guard_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gate_hi   (gate_hi),
  .gate_lo   (gate_lo),
  .triac_en  (triac_en),
  .relay_en  (relay_en),
  .fault_code(fault_code),
  .uv_now    (uv_now),
  .oc_over   (oc_over),
  .oc_trip   (oc_trip),
  .clr_ok    (clr_ok)
);

// File: tb/tb_cell_guard.sv
`timescale 1ns/1ps
module tb_cell_guard;
  localparam int VW = 12, IW = 12, OCN = 10, RW = 16, DW = 4;
  localparam int DEAD = 3, HOLD = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [VW-1:0] volt_smp = 12'd2000, volt_floor = 12'd500;
  logic uv_cmp = 1'b0, oc_cmp = 1'b0;
  logic [IW-1:0] curr_smp = 12'd100, curr_limit = 12'd1000;
  logic [RW-1:0] relay_time = RW'(HOLD);
  logic [DW-1:0] dead_cycles = DW'(DEAD);
  logic pwm_in = 1'b0, clear_req = 1'b0;
  logic gate_hi, gate_lo, triac_en, relay_en, fault_irq;
  logic [1:0] fault_code;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cell_guard #(.VW(VW), .IW(IW), .OC_CYCLES(OCN), .RW(RW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .volt_smp(volt_smp), .volt_floor(volt_floor),
    .uv_cmp(uv_cmp), .curr_smp(curr_smp), .curr_limit(curr_limit), .oc_cmp(oc_cmp),
    .relay_time(relay_time), .dead_cycles(dead_cycles), .pwm_in(pwm_in),
    .clear_req(clear_req), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .triac_en(triac_en), .relay_en(relay_en), .fault_code(fault_code),
    .fault_irq(fault_irq));

  // expected steady gate pair from the requirement: hi follows pwm, lo its inverse
  function automatic int exp_pair(input bit pwm, input bit faulted);
    if (faulted) return 0;
    return pwm ? 2 : 1;
  endfunction

  function automatic int pair(input logic h, input logic l);
    return {h, l};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1 reset state
    repeat (3) step();
    chk(pair(gate_hi, gate_lo) == 0 && !triac_en && !relay_en, "R1 outputs in reset",
        pair(gate_hi, gate_lo) + 4*triac_en + 8*relay_en, 0);
    chk(fault_code == 0 && !fault_irq, "R1 code in reset", fault_code, 0);
    rst_n = 1'b1;
    step();
    chk(fault_code == 0 && !triac_en && !relay_en && !fault_irq, "R1 after release",
        fault_code, 0);
    repeat (3) step();
    // R9 steady low side
    chk(pair(gate_hi, gate_lo) == exp_pair(0, 0), "R9 steady pwm=0",
        pair(gate_hi, gate_lo), exp_pair(0, 0));

    // R6 directed dead band timing
    pwm_in = 1'b1;
    for (int k = 1; k <= DEAD + 2; k++) begin
      step();
      if (k <= DEAD + 1)
        chk(pair(gate_hi, gate_lo) == 0, "R6 dead band off", pair(gate_hi, gate_lo), 0);
      else
        chk(pair(gate_hi, gate_lo) == 2, "R6 turn-on edge", pair(gate_hi, gate_lo), 2);
    end

    // random traffic with short over-limit bursts that must not trip
    for (int it = 0; it < 300; it++) begin
      int burst, hold;
      curr_limit = IW'(100 + $urandom % 3000);
      volt_floor = VW'(100 + $urandom % 1000);
      volt_smp   = VW'(int'(volt_floor) + 1 + $urandom % 1000);
      curr_smp   = IW'($urandom % (int'(curr_limit) + 1));
      pwm_in     = 1'($urandom);
      burst = $urandom % (OCN + 1);
      for (int b = 0; b < burst; b++) begin
        if ($urandom % 2) begin curr_smp = IW'(int'(curr_limit) + 1 + $urandom % 500); oc_cmp = 0; end
        else begin curr_smp = 12'd0; oc_cmp = 1; end
        step();
        chk(fault_code == 0, "R3 short burst no trip", fault_code, 0);
        chk(!(gate_hi && gate_lo), "R6 no overlap", pair(gate_hi, gate_lo), 1);
      end
      oc_cmp = 0;
      curr_smp = IW'($urandom % (int'(curr_limit) + 1));
      hold = DEAD + 3 + $urandom % 8;
      for (int h = 0; h < hold; h++) begin
        step();
        chk(!(gate_hi && gate_lo), "R6 no overlap", pair(gate_hi, gate_lo), 1);
      end
      chk(pair(gate_hi, gate_lo) == exp_pair(pwm_in, 0) && fault_code == 0,
          "R9 random steady", pair(gate_hi, gate_lo), exp_pair(pwm_in, 0));
    end

    // R3 / R4 / R5 overcurrent at the exact boundary
    curr_limit = 12'd1000; volt_floor = 12'd500; volt_smp = 12'd2000;
    curr_smp = 12'd100; pwm_in = 1'b0;
    repeat (8) step();
    curr_smp = 12'd1001;
    for (int k = 1; k < OCN; k++) begin
      step();
      chk(fault_code == 0 && pair(gate_hi, gate_lo) == 1 && !triac_en,
          "R3 no trip before window", pair(gate_hi, gate_lo), 1);
    end
    step(); // condition now present at OCN edges
    chk(pair(gate_hi, gate_lo) == 0, "R4 same-cycle kill", pair(gate_hi, gate_lo), 0);
    chk(triac_en == 1 && fault_code == 0, "R5 triac same cycle", triac_en, 1);
    step(); // latching edge
    chk(fault_code == 2 && fault_irq, "R3 overcurrent code", fault_code, 2);
    for (int j = 1; j <= HOLD + 1; j++) begin
      step();
      chk(relay_en == (j == HOLD + 1) && triac_en, "R5 relay timing", relay_en, j == HOLD + 1);
    end
    clear_req = 1'b1;
    step();
    chk(fault_code == 2 && relay_en && triac_en, "R8 clear ignored under fault", fault_code, 2);
    curr_smp = 12'd100;
    step();
    clear_req = 1'b0;
    chk(fault_code == 0 && !fault_irq && !triac_en && !relay_en, "R8 clear accepted",
        fault_code, 0);
    repeat (DEAD + 3) step();
    chk(pair(gate_hi, gate_lo) == 1, "R9 gates resume", pair(gate_hi, gate_lo), 1);

    // R2 undervoltage via sample, immediate
    volt_smp = 12'd499;
    #1;
    chk(pair(gate_hi, gate_lo) == 0 && triac_en, "R4 uv same-cycle kill", pair(gate_hi, gate_lo), 0);
    step();
    chk(fault_code == 1 && fault_irq, "R2 undervoltage code", fault_code, 1);
    volt_smp = 12'd500; // equal to floor is not under
    oc_cmp = 1'b1;
    repeat (OCN + 3) step();
    chk(fault_code == 1, "R7 code not overwritten", fault_code, 1);
    oc_cmp = 1'b0; clear_req = 1'b1;
    step();
    clear_req = 1'b0;
    chk(fault_code == 0, "R8 clear uv", fault_code, 0);

    // R2 via comparator flag
    uv_cmp = 1'b1;
    step();
    uv_cmp = 1'b0;
    chk(fault_code == 1, "R2 uv comparator flag", fault_code, 1);
    clear_req = 1'b1; step(); clear_req = 1'b0;
    chk(fault_code == 0, "R8 clear after flag", fault_code, 0);

    // R7 simultaneous trips: uv arrives on the same edge as oc qualifies
    curr_smp = 12'd1500;
    repeat (OCN - 1) step();
    chk(fault_code == 0, "R7 pre-trip", fault_code, 0);
    step();
    volt_smp = 12'd10;
    step();
    chk(fault_code == 1, "R7 uv priority", fault_code, 1);
    curr_smp = 12'd100; volt_smp = 12'd2000;
    clear_req = 1'b1; step(); clear_req = 1'b0;
    chk(fault_code == 0 && !relay_en, "R8 final clear", fault_code, 0);

    finish_run();
  end
endmodule